// File: doc/BRIEF.md
# I2C Interrupt Status and Vector Unit

This block gathers the single-cycle event pulses of an I2C controller into sticky status flags. It gates those flags with a software-programmed enable mask and drives one interrupt line. It also computes a small vector code naming the most urgent pending, enabled event. Software reaches three registers over a simple register port: the enable mask, the status word and the vector. Software clears status flags by writing ones to them. Reading the vector acknowledges the source it names, so an interrupt handler can keep reading the vector until it returns zero.

The two data-ready sources (receive ready and transmit ready) are not acknowledged by a vector read. They stay pending until the controller's data path reports a read of the receive data register or a write of the transmit data register. The status word also carries two live bus levels, bus busy and receive shift register full. These are not flags and cannot be cleared.

Top module: `i2c_irq_vector`

## Requirements
- R1: After reset the mask register, all status flags, `irq_o` and `vector_o` are zero.
- R2: A pulse on `evt_i[k]` sets status flag k from the next cycle on, whether or not mask bit k is set. The bit order is: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave.
- R3: Writing the status register (address 1) clears every flag whose write-data bit is 1. Flags whose write-data bit is 0 are unchanged.
- R4: When an event pulse and any clear of the same flag fall in the same cycle, the flag ends up set.
- R5: `irq_o` is 1 exactly when some flag k in bits 0..6 is set while mask bit k is also set.
- R6: `vector_o`, and a read of the vector register (address 2), give k+1 for the lowest-numbered flag k that is both set and enabled. They give 0 when no such flag exists.
- R7: A flag whose mask bit is 0 is never reported in the vector and never raises `irq_o`.
- R8: A vector read that returns code c clears flag c-1 on the following edge. The exception is c = 4 or c = 5: those flags stay set, and later reads return the same code.
- R9: A pulse on `rx_data_rd_i` clears the receive-ready flag (bit 3). A pulse on `tx_data_wr_i` clears the transmit-ready flag (bit 4).
- R10: Status bit 12 follows `bus_busy_i` and status bit 11 follows `rx_shift_full_i`, in the same cycle. Status bits 7..10 and 13..15 read 0.
- R11: The mask register (address 0) stores write-data bits 0..6 and reads 0 in bits 7..15. Address 3 reads 0.
- R12: Reading the vector over and over returns the pending enabled sources in ascending code order and then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| evt_i | input | 7 | One-cycle event pulses, one bit per source |
| bus_busy_i | input | 1 | Live bus-busy level |
| rx_shift_full_i | input | 1 | Live receive-shift-register-full level |
| rx_data_rd_i | input | 1 | Pulse: receive data register was read |
| tx_data_wr_i | input | 1 | Pulse: transmit data register was written |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address: 0 mask, 1 status, 2 vector |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from the address |
| irq_o | output | 1 | Interrupt request |
| vector_o | output | 3 | Code of the top-priority pending enabled source |
| status_o | output | 16 | Live status word |

## Verification
Some properties are checked on every cycle:
- An event always lands in its flag one cycle later, even when a clear hits the same bit.
- No flag ever rises without an event.
- The interrupt line agrees with a non-zero vector.
- Any reported code points at a flag that is both set and enabled.
- Acknowledge reads and data-register strobes really drop their flag.
- The bus-busy bit tracks its input.

Other behaviour only the bench scenarios can show:
- The priority order that repeated vector reads walk through.
- The sticky behaviour of the two data-ready codes under repeated reads.
- Write-one-to-clear with mixed zero and one data bits.
- The widths the mask register keeps when read back.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

  typedef enum logic [1:0] {
    RA_MASK = 2'd0,
    RA_STAT = 2'd1,
    RA_VEC  = 2'd2,
    RA_RSVD = 2'd3
  } reg_addr_e;

  // Sources whose flags only a data register access can clear.
  localparam int SRC_RX = 3;
  localparam int SRC_TX = 4;

endpackage

// File: rtl/i2c_irq_flag_bank.sv
module i2c_irq_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);

  logic [N-1:0] flag_q;
  logic [N-1:0] flag_d;
  logic [N-1:0] flag_en;

  for (genvar k = 0; k < N; k++) begin : g_flag
    // Next-state: a set has priority over a clear in the same cycle.
    always_comb begin
      flag_en[k] = set_i[k] | clr_i[k];
      flag_d[k]  = set_i[k] | (flag_q[k] & ~clr_i[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[k] <= 1'b0;
      end else if (flag_en[k]) begin
        flag_q[k] <= flag_d[k];
      end
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/i2c_irq_prio_enc.sv
module i2c_irq_prio_enc #(
  parameter int N  = 7,
  parameter int VW = $clog2(N + 1)
) (
  input  logic [N-1:0]  pend_i,
  output logic [VW-1:0] code_o,
  output logic [N-1:0]  sel_o
);

  // The lowest index wins; code is index + 1, zero when idle.
  always_comb begin
    code_o = '0;
    sel_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        code_o = VW'(i + 1);
        sel_o  = N'(1) << i;
      end
    end
  end

endmodule

// File: rtl/i2c_irq_regif.sv
module i2c_irq_regif
  import i2c_irq_pkg::*;
#(
  parameter int N     = 7,
  parameter int VW    = 3,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  input  logic [REG_W-1:0] status_i,
  input  logic [VW-1:0]    code_i,
  output logic [N-1:0]     mask_o,
  output logic [N-1:0]     w1c_o,
  output logic             vec_rd_o,
  output logic [REG_W-1:0] reg_rdata_o
);

  reg_addr_e    addr;
  logic [N-1:0] mask_q;
  logic [N-1:0] mask_d;
  logic         mask_en;

  assign addr = reg_addr_e'(reg_addr_i);

  always_comb begin
    mask_en  = reg_wr_i && (addr == RA_MASK);
    mask_d   = reg_wdata_i[N-1:0];
    w1c_o    = (reg_wr_i && (addr == RA_STAT)) ? reg_wdata_i[N-1:0] : '0;
    vec_rd_o = reg_rd_i && (addr == RA_VEC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_comb begin
    unique case (addr)
      RA_MASK: reg_rdata_o = REG_W'(mask_q);
      RA_STAT: reg_rdata_o = status_i;
      RA_VEC:  reg_rdata_o = REG_W'(code_i);
      default: reg_rdata_o = '0;
    endcase
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/i2c_irq_vector.sv
module i2c_irq_vector
  import i2c_irq_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int REG_W   = 16,
  parameter int BB_BIT  = 12,
  parameter int RSF_BIT = 11,
  parameter int VW      = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               bus_busy_i,
  input  logic               rx_shift_full_i,
  input  logic               rx_data_rd_i,
  input  logic               tx_data_wr_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               irq_o,
  output logic [VW-1:0]      vector_o,
  output logic [REG_W-1:0]   status_o
);

  localparam logic [NUM_SRC-1:0] DATA_SRC =
    (NUM_SRC'(1) << SRC_RX) | (NUM_SRC'(1) << SRC_TX);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] w1c;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] top_sel;
  logic [NUM_SRC-1:0] ack_clr;
  logic [NUM_SRC-1:0] data_clr;
  logic [NUM_SRC-1:0] clr_all;
  logic [VW-1:0]      code;
  logic               vec_rd;
  logic [REG_W-1:0]   status_w;

  always_comb begin
    pend    = flags & mask;
    ack_clr = vec_rd ? (top_sel & ~DATA_SRC) : '0;
    data_clr = '0;
    data_clr[SRC_RX] = rx_data_rd_i;
    data_clr[SRC_TX] = tx_data_wr_i;
    clr_all = w1c | ack_clr | data_clr;
  end

  always_comb begin
    status_w          = '0;
    status_w[NUM_SRC-1:0] = flags;
    status_w[BB_BIT]  = bus_busy_i;
    status_w[RSF_BIT] = rx_shift_full_i;
  end

  i2c_irq_flag_bank #(
    .N (NUM_SRC)
  ) u_flags (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (evt_i),
    .clr_i  (clr_all),
    .flag_o (flags)
  );

  i2c_irq_prio_enc #(
    .N  (NUM_SRC),
    .VW (VW)
  ) u_prio (
    .pend_i (pend),
    .code_o (code),
    .sel_o  (top_sel)
  );

  i2c_irq_regif #(
    .N     (NUM_SRC),
    .VW    (VW),
    .REG_W (REG_W)
  ) u_regif (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .status_i    (status_w),
    .code_i      (code),
    .mask_o      (mask),
    .w1c_o       (w1c),
    .vec_rd_o    (vec_rd),
    .reg_rdata_o (reg_rdata_o)
  );

  assign irq_o    = |pend;
  assign vector_o = code;
  assign status_o = status_w;

endmodule

// File: rtl/i2c_irq_vector_chk.sv
module i2c_irq_vector_chk #(
  parameter int NUM_SRC = 7,
  parameter int REG_W   = 16,
  parameter int BB_BIT  = 12,
  parameter int VW      = 3
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               bus_busy_i,
  input logic               rx_data_rd_i,
  input logic               tx_data_wr_i,
  input logic               reg_rd_i,
  input logic [1:0]         reg_addr_i,
  input logic [NUM_SRC-1:0] mask,
  input logic               irq_o,
  input logic [VW-1:0]      vector_o,
  input logic [REG_W-1:0]   status_o
);

  logic vec_rd;
  assign vec_rd = reg_rd_i && (reg_addr_i == 2'd2);

  // R2 R4
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((status_o[NUM_SRC-1:0] & $past(evt_i)) == $past(evt_i)));

  // R3
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((status_o[NUM_SRC-1:0] & ~$past(status_o[NUM_SRC-1:0])
               & ~$past(evt_i)) == '0));

  // R5
  irq_vs_vector_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o == (vector_o != '0));

  // R6 R7
  vector_valid_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vector_o != '0) |-> (status_o[vector_o - 3'd1] && mask[vector_o - 3'd1]));

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vec_rd && vector_o != '0 && vector_o != 3'd4 && vector_o != 3'd5
     && !evt_i[vector_o - 3'd1])
    |=> !status_o[$past(vector_o) - 3'd1]);

  // R9
  rx_data_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_data_rd_i && !evt_i[3]) |=> !status_o[3]);

  // R9
  tx_data_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_data_wr_i && !evt_i[4]) |=> !status_o[4]);

  // R10
  busy_bit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    status_o[BB_BIT] == bus_busy_i);

endmodule

bind i2c_irq_vector i2c_irq_vector_chk #(
  .NUM_SRC (NUM_SRC),
  .REG_W   (REG_W),
  .BB_BIT  (BB_BIT),
  .VW      (VW)
) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .evt_i        (evt_i),
  .bus_busy_i   (bus_busy_i),
  .rx_data_rd_i (rx_data_rd_i),
  .tx_data_wr_i (tx_data_wr_i),
  .reg_rd_i     (reg_rd_i),
  .reg_addr_i   (reg_addr_i),
  .mask         (mask),
  .irq_o        (irq_o),
  .vector_o     (vector_o),
  .status_o     (status_o)
);

// File: tb/tb_i2c_irq_vector.sv
module tb_i2c_irq_vector;

  logic        clk;
  logic        rst_n;
  logic [6:0]  evt_i;
  logic        bus_busy_i;
  logic        rx_shift_full_i;
  logic        rx_data_rd_i;
  logic        tx_data_wr_i;
  logic        reg_wr_i;
  logic        reg_rd_i;
  logic [1:0]  reg_addr_i;
  logic [15:0] reg_wdata_i;
  logic [15:0] reg_rdata_o;
  logic        irq_o;
  logic [2:0]  vector_o;
  logic [15:0] status_o;

  i2c_irq_vector dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .evt_i           (evt_i),
    .bus_busy_i      (bus_busy_i),
    .rx_shift_full_i (rx_shift_full_i),
    .rx_data_rd_i    (rx_data_rd_i),
    .tx_data_wr_i    (tx_data_wr_i),
    .reg_wr_i        (reg_wr_i),
    .reg_rd_i        (reg_rd_i),
    .reg_addr_i      (reg_addr_i),
    .reg_wdata_i     (reg_wdata_i),
    .reg_rdata_o     (reg_rdata_o),
    .irq_o           (irq_o),
    .vector_o        (vector_o),
    .status_o        (status_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef enum int { K_RDATA, K_STATUS, K_IRQ, K_VEC } kind_e;
  typedef struct {
    kind_e       kind;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    n_checks = 0;
  int    n_errors = 0;
  bit    finished = 0;

  // Monitor: pops expected items and compares with the outputs.
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = q.pop_front();
        case (it.kind)
          K_RDATA:  act = reg_rdata_o;
          K_STATUS: act = status_o;
          K_IRQ:    act = {15'd0, irq_o};
          default:  act = {13'd0, vector_o};
        endcase
        n_checks++;
        if (act !== it.exp) begin
          n_errors++;
          $display("FAIL %s kind=%0d actual=0x%04h expected=0x%04h",
                   it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic expect_out(kind_e k, logic [15:0] e, string r);
    item_t it;
    it.kind = k;
    it.exp  = e;
    it.req  = r;
    q.push_back(it);
    ->chk_ev;
    #1;
  endtask

  task automatic pulse(logic [6:0] m);
    @(negedge clk);
    evt_i = m;
    @(negedge clk);
    evt_i = '0;
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
    #1;
  endtask

  task automatic rd(logic [1:0] a, logic [15:0] e, string r);
    @(negedge clk);
    reg_rd_i = 1'b1; reg_addr_i = a;
    #1;
    expect_out(K_RDATA, e, r);
    @(negedge clk);
    reg_rd_i = 1'b0;
    #1;
  endtask

  task automatic data_strobe(bit is_rx);
    @(negedge clk);
    if (is_rx) rx_data_rd_i = 1'b1; else tx_data_wr_i = 1'b1;
    @(negedge clk);
    rx_data_rd_i = 1'b0; tx_data_wr_i = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    evt_i = '0; bus_busy_i = 0; rx_shift_full_i = 0;
    rx_data_rd_i = 0; tx_data_wr_i = 0;
    reg_wr_i = 0; reg_rd_i = 0; reg_addr_i = '0; reg_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;

    // R1 reset state
    expect_out(K_STATUS, 16'h0000, "R1");
    expect_out(K_IRQ,    16'h0000, "R1");
    expect_out(K_VEC,    16'h0000, "R1");
    rd(2'd0, 16'h0000, "R1");

    // R2 R7 masked event still sets its flag
    pulse(7'h01);
    expect_out(K_STATUS, 16'h0001, "R2");
    expect_out(K_IRQ,    16'h0000, "R7");
    expect_out(K_VEC,    16'h0000, "R7");

    // R5 R6 enabling the mask raises irq and vector
    wr(2'd0, 16'h007F);
    expect_out(K_IRQ, 16'h0001, "R5");
    expect_out(K_VEC, 16'h0001, "R6");

    // R3 write-one-to-clear
    wr(2'd1, 16'h0000);
    expect_out(K_STATUS, 16'h0001, "R3");
    wr(2'd1, 16'h0001);
    expect_out(K_STATUS, 16'h0000, "R3");
    expect_out(K_IRQ,    16'h0000, "R5");

    // R4 event and clear on the same cycle
    @(negedge clk);
    evt_i = 7'h02; reg_wr_i = 1'b1; reg_addr_i = 2'd1; reg_wdata_i = 16'h0002;
    @(negedge clk);
    evt_i = '0; reg_wr_i = 1'b0; reg_wdata_i = '0;
    #1;
    expect_out(K_STATUS, 16'h0002, "R4");

    // R8 R12 acknowledge reads walk priority order
    pulse(7'h64);
    expect_out(K_STATUS, 16'h0066, "R2");
    expect_out(K_VEC,    16'h0002, "R6");
    rd(2'd2, 16'h0002, "R12");
    expect_out(K_STATUS, 16'h0064, "R8");
    rd(2'd2, 16'h0003, "R12");
    rd(2'd2, 16'h0006, "R12");
    rd(2'd2, 16'h0007, "R12");
    rd(2'd2, 16'h0000, "R12");
    expect_out(K_STATUS, 16'h0000, "R8");
    expect_out(K_IRQ,    16'h0000, "R5");

    // R8 R9 data-ready sources stay until a data access
    pulse(7'h18);
    rd(2'd2, 16'h0004, "R8");
    expect_out(K_STATUS, 16'h0018, "R8");
    rd(2'd2, 16'h0004, "R8");
    data_strobe(1'b1);
    expect_out(K_STATUS, 16'h0010, "R9");
    rd(2'd2, 16'h0005, "R8");
    expect_out(K_STATUS, 16'h0010, "R8");
    data_strobe(1'b0);
    expect_out(K_STATUS, 16'h0000, "R9");
    expect_out(K_VEC,    16'h0000, "R9");

    // R7 a masked higher-priority source is skipped
    wr(2'd0, 16'h0020);
    pulse(7'h21);
    expect_out(K_STATUS, 16'h0021, "R2");
    expect_out(K_VEC,    16'h0006, "R7");
    expect_out(K_IRQ,    16'h0001, "R5");
    wr(2'd0, 16'h0000);
    expect_out(K_IRQ, 16'h0000, "R7");
    expect_out(K_VEC, 16'h0000, "R7");

    // R10 live bus levels in the status word
    wr(2'd1, 16'h007F);
    expect_out(K_STATUS, 16'h0000, "R3");
    @(negedge clk);
    bus_busy_i = 1'b1; rx_shift_full_i = 1'b1;
    #1;
    expect_out(K_STATUS, 16'h1800, "R10");
    @(negedge clk);
    bus_busy_i = 1'b0;
    #1;
    expect_out(K_STATUS, 16'h0800, "R10");
    rd(2'd1, 16'h0800, "R10");
    rx_shift_full_i = 1'b0;

    // R11 mask width and reserved address
    wr(2'd0, 16'hFFFF);
    rd(2'd0, 16'h007F, "R11");
    rd(2'd3, 16'h0000, "R11");

    finished = 1;
    #1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule